// File: doc/BRIEF.md
# Register-Programmable Integer Clock Divider

This block derives a slower clock from one input clock. The division ratio comes from a bit field inside a 32-bit control register. Software writes and reads that register through a simple port. The field's bit offset and width are fixed at build time. A build-time choice also sets how a field code turns into a divisor. There are four mappings: code plus one, code taken as it is, two to the power of the code, or a lookup list in which a zero entry marks a code as unusable. A code that decodes to zero does not stop the clock. It selects the bypass path, and the output follows the input clock.

The register supports three kinds of write. A full write replaces all 32 bits. A field-only update changes just the divider bits and keeps every other bit as it was. When the masked-halfword option is built in, a full write instead treats its upper 16 bits as a per-bit enable for its lower 16 bits. A new ratio is never applied in the middle of an output period. It is held pending and loaded when the running period ends. A status output shows the ratio that is in force now.

Top module: `prog_clk_div`

## Requirements
- R1: With the plus-one mapping, field code f gives divisor f+1 (code 0 gives 1, code 2 gives 3).
- R2: With the direct mapping, field code f gives divisor f, and code 0 decodes to zero and selects bypass.
- R3: With the power-of-two mapping, field code f gives divisor 2^f (code 2 gives 4, code 3 gives 8).
- R4: With the table mapping, code f selects list entry f, where entry i sits at bits [i*DIV_W +: DIV_W] of the table parameter; an entry of 0 selects bypass.
- R5: The field occupies bits [FIELD_SHIFT +: FIELD_WIDTH] of the register; no other register bit affects the divisor.
- R6: A write with `fieldOnly` high loads `wrData[FIELD_WIDTH-1:0]` into the field and leaves all other bits unchanged; a plain write without the masked option loads all 32 bits.
- R7: With the masked option, a plain write updates bit i of [15:0] only where `wrData[16+i]` is 1, and bits [31:16] always read as 0.
- R8: A changed divisor takes effect only on the clock edge that ends the current output period; until then `divStatus` keeps the old value.
- R9: For a divisor N of 2 or more, `clkOut` stays high for floor(N/2) input cycles at the start of each period and low for the remaining cycles.
- R10: When the applied divisor is 1, `clkOut` follows `clk`.
- R11: Synchronous active-high `rst` loads the register with the code that decodes to divide-by-1 under the chosen mapping, and `divStatus` reads 1.
- R12: `divStatus` reports the applied divisor, which is always nonzero; a bypass code reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| fieldOnly | input | 1 | With wrEn, update only the divider field |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register contents |
| clkOut | output | 1 | Divided clock |
| divStatus | output | DIV_W | Divisor currently applied |

## Verification
The hardest case to reach is a ratio change that arrives in the middle of a long period. In that case the pending value must stay invisible until the exact edge that ends the period. The bench first runs divide-by-6 and watches the output until it sees a period begin. In that same cycle it writes a new ratio, then checks the status on the fifth cycle after the write (still old) and on the sixth (new). Bypass codes are reached through each mapping's own invalid code: code 0 under the direct mapping and a zero list entry under the table mapping.

// File: rtl/divPkg.sv
package divPkg;

  typedef enum logic [1:0] {
    ENC_PLUS_ONE = 2'd0,
    ENC_DIRECT   = 2'd1,
    ENC_POW2     = 2'd2,
    ENC_TABLE    = 2'd3
  } encSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // take newDiv at this period boundary
    logic toBypass;  // new ratio is 1: route clk straight through
  } divCmd_t;

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter encSel_t ENCODING    = ENC_PLUS_ONE,
  parameter int      FIELD_SHIFT = 0,
  parameter int      FIELD_WIDTH = 4,
  parameter int      DIV_W       = 16,
  parameter bit      HALF_MASK   = 1'b0,
  parameter logic [(1<<FIELD_WIDTH)-1:0][DIV_W-1:0] DIV_TABLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             fieldOnly,
  input  logic [31:0]      wrData,
  input  logic             periodEnd,
  input  logic [DIV_W-1:0] curDiv,
  output logic [31:0]      rdData,
  output logic [DIV_W-1:0] newDiv,
  output divCmd_t          cmd
);

  localparam int TABLE_LEN = 1 << FIELD_WIDTH;
  localparam logic [31:0] FIELD_MASK =
    ((32'd1 << FIELD_WIDTH) - 32'd1) << FIELD_SHIFT;

  function automatic logic [FIELD_WIDTH-1:0] unityCode();
    logic [FIELD_WIDTH-1:0] code;
    code = '0;
    if (ENCODING == ENC_DIRECT) begin
      code = FIELD_WIDTH'(1);
    end else if (ENCODING == ENC_TABLE) begin
      // prefer an entry of 1; otherwise the lowest invalid code
      for (int i = TABLE_LEN - 1; i >= 0; i--)
        if (DIV_TABLE[i] == '0) code = FIELD_WIDTH'(i);
      for (int i = TABLE_LEN - 1; i >= 0; i--)
        if (DIV_TABLE[i] == DIV_W'(1)) code = FIELD_WIDTH'(i);
    end
    return code;
  endfunction

  localparam logic [FIELD_WIDTH-1:0] RST_CODE = unityCode();
  localparam logic [31:0] RST_VALUE = 32'(RST_CODE) << FIELD_SHIFT;

  logic [31:0]            ctrlReg;
  logic [31:0]            ctrlNext;
  logic [FIELD_WIDTH-1:0] fieldVal;
  logic [DIV_W-1:0]       decoded;
  logic [DIV_W-1:0]       effDiv;

  // register update
  always_comb begin
    ctrlNext = ctrlReg;
    if (wrEn) begin
      if (fieldOnly) begin
        ctrlNext = (ctrlReg & ~FIELD_MASK) |
                   ((32'(wrData[FIELD_WIDTH-1:0]) << FIELD_SHIFT) & FIELD_MASK);
      end else if (HALF_MASK) begin
        ctrlNext[15:0]  = (ctrlReg[15:0] & ~wrData[31:16]) |
                          (wrData[15:0] & wrData[31:16]);
        ctrlNext[31:16] = '0;
      end else begin
        ctrlNext = wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrlReg <= RST_VALUE;
    else     ctrlReg <= ctrlNext;
  end

  assign rdData   = ctrlReg;
  assign fieldVal = ctrlReg[FIELD_SHIFT +: FIELD_WIDTH];

  // code to divisor
  generate
    if (ENCODING == ENC_PLUS_ONE) begin : gPlusOne
      assign decoded = DIV_W'(fieldVal) + DIV_W'(1);
    end else if (ENCODING == ENC_DIRECT) begin : gDirect
      assign decoded = DIV_W'(fieldVal);
    end else if (ENCODING == ENC_POW2) begin : gPow2
      assign decoded = (32'(fieldVal) < DIV_W) ? (DIV_W'(1) << fieldVal) : '0;
    end else begin : gTable
      assign decoded = DIV_TABLE[fieldVal];
    end
  endgenerate

  assign effDiv = (decoded == '0) ? DIV_W'(1) : decoded;

  // only hand over a ratio when it differs and the period is over
  always_comb begin
    newDiv       = effDiv;
    cmd.toBypass = (effDiv == DIV_W'(1));
    cmd.load     = periodEnd && (effDiv != curDiv);
  end

endmodule

// File: rtl/divCore.sv
module divCore
  import divPkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  divCmd_t          cmd,
  input  logic [DIV_W-1:0] newDiv,
  output logic             periodEnd,
  output logic [DIV_W-1:0] curDiv,
  output logic             bypass,
  output logic             divLevel,
  output logic [DIV_W-1:0] cnt,
  output logic             clkOut
);

  logic [DIV_W-1:0] cntInc;
  logic [DIV_W-1:0] halfDiv;

  assign cntInc    = cnt + DIV_W'(1);
  assign halfDiv   = curDiv >> 1;
  assign periodEnd = bypass || (cnt == curDiv - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      curDiv   <= DIV_W'(1);
      bypass   <= 1'b1;
      divLevel <= 1'b0;
    end else if (cmd.load) begin
      curDiv   <= newDiv;
      bypass   <= cmd.toBypass;
      cnt      <= '0;
      divLevel <= !cmd.toBypass;
    end else if (periodEnd) begin
      cnt      <= '0;
      divLevel <= !bypass;
    end else begin
      cnt      <= cntInc;
      divLevel <= (cntInc < halfDiv);
    end
  end

  // select flips on a rising edge, when both paths rise together
  assign clkOut = bypass ? clk : divLevel;

endmodule

// File: rtl/prog_clk_div.sv
module prog_clk_div
  import divPkg::*;
#(
  parameter encSel_t ENCODING    = ENC_PLUS_ONE,
  parameter int      FIELD_SHIFT = 0,
  parameter int      FIELD_WIDTH = 4,
  parameter int      DIV_W       = 16,
  parameter bit      HALF_MASK   = 1'b0,
  parameter logic [(1<<FIELD_WIDTH)-1:0][DIV_W-1:0] DIV_TABLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             fieldOnly,
  input  logic [31:0]      wrData,
  output logic [31:0]      rdData,
  output logic             clkOut,
  output logic [DIV_W-1:0] divStatus
);

  divCmd_t          cmd;
  logic [DIV_W-1:0] newDiv;
  logic [DIV_W-1:0] curDiv;
  logic [DIV_W-1:0] cnt;
  logic             periodEnd;
  logic             bypass;
  logic             divLevel;

  divCtrl #(
    .ENCODING(ENCODING), .FIELD_SHIFT(FIELD_SHIFT), .FIELD_WIDTH(FIELD_WIDTH),
    .DIV_W(DIV_W), .HALF_MASK(HALF_MASK), .DIV_TABLE(DIV_TABLE)
  ) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .fieldOnly(fieldOnly), .wrData(wrData),
    .periodEnd(periodEnd), .curDiv(curDiv), .rdData(rdData),
    .newDiv(newDiv), .cmd(cmd)
  );

  divCore #(.DIV_W(DIV_W)) uCore (
    .clk(clk), .rst(rst), .cmd(cmd), .newDiv(newDiv),
    .periodEnd(periodEnd), .curDiv(curDiv), .bypass(bypass),
    .divLevel(divLevel), .cnt(cnt), .clkOut(clkOut)
  );

  assign divStatus = curDiv;

endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int DIV_W     = 16,
  parameter bit HALF_MASK = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             periodEnd,
  input logic             bypass,
  input logic             divLevel,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] divStatus,
  input logic [31:0]      rdData
);

  AST_STATUS_NONZERO: assert property (@(posedge clk) disable iff (rst)
    divStatus != '0); // R12

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> $stable(divStatus)); // R8

  AST_PERIOD_TAIL_LOW: assert property (@(posedge clk) disable iff (rst)
    (periodEnd && !bypass) |-> !divLevel); // R9

  AST_PERIOD_OPENS_HIGH: assert property (@(posedge clk) disable iff (rst)
    periodEnd |=> (bypass || divLevel)); // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !bypass |-> (cnt < divStatus)); // R9

  AST_BYPASS_UNITY: assert property (@(posedge clk) disable iff (rst)
    bypass |-> (divStatus == DIV_W'(1))); // R10

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (HALF_MASK != 1'b0) |-> (rdData[31:16] == 16'h0)); // R7

endmodule

bind prog_clk_div divChecker #(.DIV_W(DIV_W), .HALF_MASK(HALF_MASK)) chk (
  .clk(clk), .rst(rst), .periodEnd(periodEnd), .bypass(bypass),
  .divLevel(divLevel), .cnt(cnt), .divStatus(divStatus), .rdData(rdData)
);

// File: tb/prog_clk_div_test.sv
module prog_clk_div_test;
  import divPkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fieldOnly = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0] wrEn = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  logic [31:0] rd0, rd1, rd2, rd3;
  logic co0, co1, co2, co3;
  logic [15:0] st0, st1, st2, st3;

  // plus-one mapping, field at bits 7:4
  prog_clk_div #(.ENCODING(ENC_PLUS_ONE), .FIELD_SHIFT(4), .FIELD_WIDTH(4)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn[0]), .fieldOnly(fieldOnly), .wrData(wrData),
    .rdData(rd0), .clkOut(co0), .divStatus(st0));

  prog_clk_div #(.ENCODING(ENC_DIRECT), .FIELD_SHIFT(0), .FIELD_WIDTH(4)) uutOne (
    .clk(clk), .rst(rst), .wrEn(wrEn[1]), .fieldOnly(fieldOnly), .wrData(wrData),
    .rdData(rd1), .clkOut(co1), .divStatus(st1));

  // power-of-two, field at bits 10:8, masked halfword writes
  prog_clk_div #(.ENCODING(ENC_POW2), .FIELD_SHIFT(8), .FIELD_WIDTH(3),
                 .HALF_MASK(1'b1)) uutPow (
    .clk(clk), .rst(rst), .wrEn(wrEn[2]), .fieldOnly(fieldOnly), .wrData(wrData),
    .rdData(rd2), .clkOut(co2), .divStatus(st2));

  // table: code0=4, code1=8, code2=invalid, code3=16
  prog_clk_div #(.ENCODING(ENC_TABLE), .FIELD_SHIFT(0), .FIELD_WIDTH(2),
                 .DIV_TABLE({16'd16, 16'd0, 16'd8, 16'd4})) uutTab (
    .clk(clk), .rst(rst), .wrEn(wrEn[3]), .fieldOnly(fieldOnly), .wrData(wrData),
    .rdData(rd3), .clkOut(co3), .divStatus(st3));

  function automatic int statusOf(int which);
    case (which)
      0: return int'(st0);
      1: return int'(st1);
      2: return int'(st2);
      default: return int'(st3);
    endcase
  endfunction

  function automatic logic clkOf(int which);
    case (which)
      0: return co0;
      1: return co1;
      2: return co2;
      default: return co3;
    endcase
  endfunction

  function automatic logic [31:0] rdOf(int which);
    case (which)
      0: return rd0;
      1: return rd1;
      2: return rd2;
      default: return rd3;
    endcase
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(int which, bit onlyField, logic [31:0] data);
    @(negedge clk);
    wrEn[which] = 1'b1;
    fieldOnly   = onlyField;
    wrData      = data;
    @(negedge clk);
    wrEn      = '0;
    fieldOnly = 1'b0;
  endtask

  task automatic waitStatus(int which, int exp, string tag);
    for (int i = 0; i < 100 && statusOf(which) != exp; i++) @(negedge clk);
    check(statusOf(which) == exp, tag, statusOf(which), exp);
  endtask

  task automatic measureDuty(int which, int expHi, int expLo, string tag);
    int hi = 0;
    int lo = 0;
    for (int i = 0; i < 200 && clkOf(which) != 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 200 && clkOf(which) != 1'b1; i++) @(negedge clk);
    for (int i = 0; i < 200 && clkOf(which) == 1'b1; i++) begin hi++; @(negedge clk); end
    for (int i = 0; i < 200 && clkOf(which) == 1'b0; i++) begin lo++; @(negedge clk); end
    check(hi == expHi, {tag, " high time"}, hi, expHi);
    check(lo == expLo, {tag, " low time"}, lo, expLo);
  endtask

  task automatic testReset();
    check(rd0 == 32'h0, "R11 plus-one reset code", rd0, 0);
    check(st0 == 16'd1, "R11 reset status", st0, 1);
    check(rd1 == 32'h1, "R11 direct reset code", rd1, 1);
    check(rd2 == 32'h0, "R11 pow2 reset code", rd2, 0);
    check(rd3 == 32'h2, "R11 table reset picks invalid code", rd3, 2);
    check(st3 == 16'd1, "R12 table reset status", st3, 1);
  endtask

  task automatic testPlusOne();
    regWrite(0, 1'b0, 32'h0000_0020);
    check(rd0 == 32'h20, "R6 full write", rd0, 32'h20);
    waitStatus(0, 3, "R1 code 2 gives 3");
    measureDuty(0, 1, 2, "R9 divide by 3");
    regWrite(0, 1'b0, 32'h0000_0050);
    waitStatus(0, 6, "R1 code 5 gives 6");
    measureDuty(0, 3, 3, "R9 divide by 6");
  endtask

  task automatic testFieldPosition();
    regWrite(0, 1'b0, 32'hFFFF_FF0F);
    waitStatus(0, 1, "R5 outside bits ignored");
    @(posedge clk); #1;
    check(co0 == 1'b1, "R10 bypass high phase", co0, 1);
    @(negedge clk); #1;
    check(co0 == 1'b0, "R10 bypass low phase", co0, 0);
    regWrite(0, 1'b1, 32'h0000_0003);
    check(rd0 == 32'hFFFF_FF3F, "R6 field-only update", rd0, 32'hFFFF_FF3F);
    waitStatus(0, 4, "R1 code 3 gives 4");
    measureDuty(0, 2, 2, "R9 divide by 4");
  endtask

  task automatic testDeferredChange();
    regWrite(0, 1'b1, 32'h0000_0005);
    waitStatus(0, 6, "R8 setup divide by 6");
    for (int i = 0; i < 50 && co0 != 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 50 && co0 != 1'b1; i++) @(negedge clk);
    // first cycle of a period: request divide by 2 now
    wrEn[0] = 1'b1; fieldOnly = 1'b1; wrData = 32'h1;
    @(negedge clk);
    wrEn = '0; fieldOnly = 1'b0;
    repeat (4) @(negedge clk);
    check(st0 == 16'd6, "R8 old ratio held to period end", st0, 6);
    @(negedge clk);
    check(st0 == 16'd2, "R8 new ratio at period end", st0, 2);
    measureDuty(0, 1, 1, "R9 divide by 2");
  endtask

  task automatic testDirect();
    regWrite(1, 1'b0, 32'h3);
    waitStatus(1, 3, "R2 code 3 gives 3");
    measureDuty(1, 1, 2, "R2 divide by 3 duty");
    regWrite(1, 1'b0, 32'h0);
    waitStatus(1, 1, "R2 code 0 bypass");
    @(posedge clk); #1;
    check(co1 == 1'b1, "R2 code 0 passes clk", co1, 1);
  endtask

  task automatic testPowMasked();
    regWrite(2, 1'b0, 32'h0700_0200);
    check(rd2 == 32'h0000_0200, "R7 masked write", rd2, 32'h200);
    waitStatus(2, 4, "R3 code 2 gives 4");
    measureDuty(2, 2, 2, "R3 divide by 4 duty");
    regWrite(2, 1'b0, 32'h0000_0500);
    check(rd2 == 32'h0000_0200, "R7 zero mask ignored", rd2, 32'h200);
    regWrite(2, 1'b0, 32'h0100_0100);
    check(rd2 == 32'h0000_0300, "R7 single bit masked", rd2, 32'h300);
    waitStatus(2, 8, "R3 code 3 gives 8");
    regWrite(2, 1'b0, 32'h00FF_00AB);
    check(rd2 == 32'h0000_03AB, "R7 low byte under mask", rd2, 32'h3AB);
    repeat (20) @(negedge clk);
    check(st2 == 16'd8, "R5 non-field bits leave divisor", st2, 8);
  endtask

  task automatic testTable();
    regWrite(3, 1'b0, 32'h0);
    waitStatus(3, 4, "R4 code 0 entry 4");
    regWrite(3, 1'b0, 32'h3);
    waitStatus(3, 16, "R4 code 3 entry 16");
    measureDuty(3, 8, 8, "R4 divide by 16 duty");
    regWrite(3, 1'b0, 32'h2);
    waitStatus(3, 1, "R4 zero entry bypass");
    regWrite(3, 1'b0, 32'h1);
    waitStatus(3, 8, "R12 status shows applied 8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testPlusOne();
    testFieldPosition();
    testDeferredChange();
    testDirect();
    testPowMasked();
    testTable();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule